// File: doc/BRIEF.md
# Configurable frame UART transceiver

This block is an asynchronous serial transmitter and receiver pair that share one run-time frame setting. The setting gives the number of data bits, from 5 to 9, the parity mode (off, even or odd) and the number of stop bits (one or two). The transmitter takes a parallel character and a one-clock start strobe and shifts a full frame out on the serial output. It reports `tx_busy` while a frame is in flight and pulses `tx_done` when the frame ends. The receiver watches the serial input, rebuilds each character and raises parity and framing error flags with it.

Both halves run from one external single-cycle baud tick at 16 times the bit rate. Each half takes a private copy of the frame setting at the start of a frame, so a setting change made during a frame applies only from the next frame. The receiver confirms a start bit at its centre and samples every later bit at its centre. It checks only the first stop bit. During a second stop bit it neither samples the line nor looks for a new start.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After reset `txd` is high, `tx_busy`, `tx_done` and `rx_valid` are low, and `rx_data`, `rx_par_err` and `rx_frm_err` are zero.
- R2: A transmitted frame is a low start bit, then the data bits with bit 0 first, then an optional parity bit, then the stop bits. Each bit lasts OVERSAMPLE baud ticks. `cfg_len` values 0 to 4 select 5 to 9 data bits, and values 5 to 7 select 9 data bits.
- R3: `cfg_par` 2'b01 selects even parity and 2'b10 selects odd parity. Even parity is the XOR of the data bits and odd parity is its inverse. Both 2'b00 and 2'b11 send no parity bit.
- R4: With `cfg_two_stop` high the frame ends with two high stop bits, and with it low the frame ends with one. The line is high between frames.
- R5: `tx_start` seen while idle is accepted, and `tx_busy` is high in the next cycle. `tx_start` seen during a frame, other than in its final tick, is ignored, and the frame in flight is unchanged. `tx_done` pulses for exactly one clock per frame.
- R6: If `tx_start` is high in the baud tick that ends the last stop bit, the next start bit follows at once with no idle bit between the frames, and `tx_busy` stays high.
- R7: For each frame received, `rx_valid` pulses for one clock. `rx_data` then holds the character with the bits above the selected length at zero. `rx_data` and both flags stay unchanged until the next frame completes.
- R8: With parity enabled, `rx_par_err` is high when the received parity bit does not match the received data. With parity disabled it is always low.
- R9: `rx_frm_err` is high only when the first stop bit is sampled low. A low second stop bit causes no error and starts no extra frame.
- R10: A low pulse on `rxd` that ends before the middle of the start bit produces no frame, and the next real frame is still received correctly.
- R11: A change to `cfg_len`, `cfg_par` or `cfg_two_stop` during a frame has no effect on that frame in either direction. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Single-cycle pulse at OVERSAMPLE times the bit rate |
| cfg_len | input | 3 | Data length select: value+5 bits, values above 4 select 9 |
| cfg_par | input | 2 | Parity mode: 01 even, 10 odd, 00 or 11 none |
| cfg_two_stop | input | 1 | High selects two stop bits |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | DATA_W | Character to send |
| tx_busy | output | 1 | Transmitter has a frame in flight |
| tx_done | output | 1 | One-clock pulse when a frame has been sent |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | One-clock pulse when a frame has been received |
| rx_par_err | output | 1 | Parity mismatch in the last frame |
| rx_frm_err | output | 1 | First stop bit of the last frame was low |

## Verification
The transmitter's end of frame and its acceptance of the next character can fall in the same clock: the baud tick that closes the last stop bit both raises `tx_done` and, when `tx_start` is already high, loads a new frame. The bench holds `tx_start` high across a whole frame with new data waiting, then releases it when `tx_done` appears. The check passes only if the second start bit begins within half a bit time of the first frame's last stop-bit centre, both frames decode correctly on `txd`, and the looped-back receiver delivers the second character. Randomly drawn lengths, parity modes and stop counts, and directed receiver frames with a bad parity bit, a bad stop bit or a runt start pulse, cover the other requirements.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

   localparam int unsigned MAX_BITS = 9;
   localparam int unsigned MIN_BITS = 5;

   typedef logic [MAX_BITS-1:0] char_t;

   typedef enum logic [1:0] {
      PAR_OFF   = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_ODD   = 2'b10,
      PAR_OFF_B = 2'b11
   } par_mode_e;

   typedef struct packed {
      logic [3:0] nbits;
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
   } frame_cfg_t;

   function automatic frame_cfg_t decode_cfg(input logic [2:0] len,
                                             input logic [1:0] par,
                                             input logic       two,
                                             input int unsigned limit);
      frame_cfg_t c;
      logic [3:0] n;
      n = (len > 3'd4) ? 4'd9 : ({1'b0, len} + 4'd5);
      if (32'(n) > limit) n = 4'(limit);
      c.nbits    = n;
      c.par_en   = (par == PAR_EVEN) || (par == PAR_ODD);
      c.par_odd  = (par == PAR_ODD);
      c.two_stop = two;
      return c;
   endfunction

   function automatic char_t keep_low(input char_t d, input logic [3:0] n);
      char_t r;
      for (int i = 0; i < MAX_BITS; i++) r[i] = (i < 32'(n)) ? d[i] : 1'b0;
      return r;
   endfunction

endpackage

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic [CNT_W-1:0] last,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign expire = tick && !clear && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (tick)   cnt_q <= expire ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= din;
         end
         assign dout = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[STAGES-2:0], din};
         end
         assign dout = s_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
   import uart_frame_pkg::*;
#(
   parameter int unsigned DATA_W     = 9,
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  frame_cfg_t        cfg_in,
   input  logic              tx_start,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              tx_done,
   output logic              txd
);
   localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVERSAMPLE - 1);

   typedef enum logic [2:0] {
      T_IDLE, T_START, T_DATA, T_PAR, T_STOP1, T_STOP2
   } tx_state_e;

   tx_state_e  state_q;
   frame_cfg_t cfg_q;
   char_t      shreg_q;
   logic       par_q;
   logic [3:0] idx_q;
   logic       done_q;
   logic       expire;
   logic       last_stop;
   logic       accept;
   char_t      load_val;

   uart_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (baud_tick),
      .clear  (state_q == T_IDLE),
      .last   (BIT_LAST),
      .expire (expire)
   );

   assign last_stop = expire && (((state_q == T_STOP1) && !cfg_q.two_stop) ||
                                 (state_q == T_STOP2));
   assign accept    = tx_start && ((state_q == T_IDLE) || last_stop);
   assign load_val  = keep_low(char_t'(tx_data), cfg_in.nbits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= T_IDLE;
         cfg_q   <= '0;
         shreg_q <= '0;
         par_q   <= 1'b0;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_stop;
         if (accept) begin
            cfg_q   <= cfg_in;
            shreg_q <= load_val;
            par_q   <= (^load_val) ^ cfg_in.par_odd;
            idx_q   <= '0;
            state_q <= T_START;
         end else if (expire) begin
            case (state_q)
               T_START: state_q <= T_DATA;
               T_DATA: begin
                  shreg_q <= shreg_q >> 1;
                  idx_q   <= idx_q + 4'd1;
                  if (idx_q == cfg_q.nbits - 4'd1)
                     state_q <= cfg_q.par_en ? T_PAR : T_STOP1;
               end
               T_PAR:   state_q <= T_STOP1;
               T_STOP1: state_q <= cfg_q.two_stop ? T_STOP2 : T_IDLE;
               default: state_q <= T_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (state_q)
         T_START: txd = 1'b0;
         T_DATA:  txd = shreg_q[0];
         T_PAR:   txd = par_q;
         default: txd = 1'b1;
      endcase
   end

   assign tx_busy = (state_q != T_IDLE);
   assign tx_done = done_q;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_frame_pkg::*;
#(
   parameter int unsigned DATA_W     = 9,
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  frame_cfg_t        cfg_in,
   input  logic              line_s,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_par_err,
   output logic              rx_frm_err
);
   localparam int unsigned CNT_W = $clog2(OVERSAMPLE);
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

   typedef enum logic [2:0] {
      R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_SKIP
   } rx_state_e;

   rx_state_e  state_q;
   frame_cfg_t cfg_q;
   char_t      dbuf_q;
   char_t      out_q;
   logic [3:0] idx_q;
   logic       acc_q;
   logic       perr_q;
   logic       prev_q;
   logic       valid_q;
   logic       par_out_q;
   logic       frm_out_q;
   logic       expire;
   logic       fall;

   uart_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (baud_tick),
      .clear  (state_q == R_IDLE),
      .last   ((state_q == R_START) ? HALF_LAST : BIT_LAST),
      .expire (expire)
   );

   assign fall = prev_q && !line_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= R_IDLE;
         cfg_q     <= '0;
         dbuf_q    <= '0;
         out_q     <= '0;
         idx_q     <= '0;
         acc_q     <= 1'b0;
         perr_q    <= 1'b0;
         prev_q    <= 1'b1;
         valid_q   <= 1'b0;
         par_out_q <= 1'b0;
         frm_out_q <= 1'b0;
      end else begin
         prev_q  <= line_s;
         valid_q <= 1'b0;
         case (state_q)
            R_IDLE: begin
               if (fall) begin
                  cfg_q   <= cfg_in;
                  state_q <= R_START;
               end
            end
            R_START: begin
               if (expire) begin
                  if (!line_s) begin
                     idx_q   <= '0;
                     dbuf_q  <= '0;
                     acc_q   <= 1'b0;
                     perr_q  <= 1'b0;
                     state_q <= R_DATA;
                  end else begin
                     state_q <= R_IDLE;
                  end
               end
            end
            R_DATA: begin
               if (expire) begin
                  dbuf_q[idx_q] <= line_s;
                  acc_q         <= acc_q ^ line_s;
                  idx_q         <= idx_q + 4'd1;
                  if (idx_q == cfg_q.nbits - 4'd1)
                     state_q <= cfg_q.par_en ? R_PAR : R_STOP;
               end
            end
            R_PAR: begin
               if (expire) begin
                  perr_q  <= (acc_q ^ cfg_q.par_odd) != line_s;
                  state_q <= R_STOP;
               end
            end
            R_STOP: begin
               if (expire) begin
                  out_q     <= dbuf_q;
                  par_out_q <= cfg_q.par_en & perr_q;
                  frm_out_q <= !line_s;
                  valid_q   <= 1'b1;
                  state_q   <= cfg_q.two_stop ? R_SKIP : R_IDLE;
               end
            end
            default: begin
               if (expire) state_q <= R_IDLE;
            end
         endcase
      end
   end

   assign rx_data    = out_q[DATA_W-1:0];
   assign rx_valid   = valid_q;
   assign rx_par_err = par_out_q;
   assign rx_frm_err = frm_out_q;
endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
   import uart_frame_pkg::*;
#(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [2:0]        cfg_len,
   input  logic [1:0]        cfg_par,
   input  logic              cfg_two_stop,
   input  logic              tx_start,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              tx_done,
   output logic              txd,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_par_err,
   output logic              rx_frm_err
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < MIN_BITS || DATA_W > MAX_BITS) begin : g_bad_w
         $error("DATA_W must lie between 5 and 9");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   frame_cfg_t cfg_now;
   logic       line_s;

   assign cfg_now = decode_cfg(cfg_len, cfg_par, cfg_two_stop, DATA_W);

   uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rxd),
      .dout  (line_s)
   );

   uart_tx_core #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .cfg_in    (cfg_now),
      .tx_start  (tx_start),
      .tx_data   (tx_data),
      .tx_busy   (tx_busy),
      .tx_done   (tx_done),
      .txd       (txd)
   );

   uart_rx_core #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .cfg_in     (cfg_now),
      .line_s     (line_s),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err)
   );
endmodule

// File: rtl/uart_frame_xcvr_chk.sv
module uart_frame_xcvr_chk #(
   parameter int unsigned DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_start,
   input logic              tx_busy,
   input logic              tx_done,
   input logic              txd,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              rx_par_err,
   input logic              rx_frm_err
);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !txd);

   assert_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && !tx_busy) |=> tx_busy);

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);

   assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> $past(tx_busy));

   assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_data));

   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable({rx_par_err, rx_frm_err}));
endmodule

bind uart_frame_xcvr uart_frame_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_start   (tx_start),
   .tx_busy    (tx_busy),
   .tx_done    (tx_done),
   .txd        (txd),
   .rx_data    (rx_data),
   .rx_valid   (rx_valid),
   .rx_par_err (rx_par_err),
   .rx_frm_err (rx_frm_err)
);

// File: tb/tb_uart_frame_xcvr.sv
`timescale 1ns/1ps
module tb_uart_frame_xcvr;
   localparam int BITCLK = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [2:0] cfg_len = 3'd3;
   logic [1:0] cfg_par = 2'b00;
   logic       cfg_two_stop = 1'b0;
   logic       tx_start = 1'b0;
   logic [8:0] tx_data = '0;
   logic       tx_busy, tx_done, txd;
   logic       rxd;
   logic [8:0] rx_data;
   logic       rx_valid, rx_par_err, rx_frm_err;
   logic       use_loop = 1'b1;
   logic       bench_rxd = 1'b1;

   int n_cmp = 0;
   int n_bad = 0;
   int valid_cnt = 0;
   int done_cnt = 0;
   logic [8:0] last_data = '0;
   logic       last_perr = 1'b0;
   logic       last_ferr = 1'b0;

   assign rxd = use_loop ? txd : bench_rxd;

   always #10 clk = ~clk;

   uart_frame_xcvr dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
      .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy),
      .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
   );

   initial begin
      forever begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            valid_cnt++;
            last_data = rx_data;
            last_perr = rx_par_err;
            last_ferr = rx_frm_err;
         end
         if (tx_done) done_cnt++;
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int nbits_of(input logic [2:0] len);
      return (len > 3'd4) ? 9 : int'(len) + 5;
   endfunction

   function automatic logic [8:0] masked(input logic [8:0] d, input logic [2:0] len);
      return d & 9'((10'h1 << nbits_of(len)) - 1);
   endfunction

   function automatic logic [12:0] build_frame(input logic [8:0] d, input logic [2:0] len,
                                               input logic [1:0] par, input logic two,
                                               input logic flip_p, input logic bad_s1,
                                               input logic bad_s2, output int cnt);
      logic [12:0] f;
      logic [8:0]  m;
      int k;
      f = '1;
      m = masked(d, len);
      k = 0;
      f[k] = 1'b0; k++;
      for (int i = 0; i < nbits_of(len); i++) begin
         f[k] = m[i]; k++;
      end
      if (par == 2'b01 || par == 2'b10) begin
         f[k] = (^m) ^ (par == 2'b10) ^ flip_p; k++;
      end
      f[k] = !bad_s1; k++;
      if (two) begin
         f[k] = !bad_s2; k++;
      end
      cnt = k;
      return f;
   endfunction

   task automatic decode_tx(input int cnt, output logic [12:0] got, output int gap);
      got = '1;
      gap = 0;
      while (txd !== 1'b0 && gap < 4000) begin
         @(negedge clk);
         gap++;
      end
      repeat (BITCLK / 2) @(negedge clk);
      got[0] = txd;
      for (int i = 1; i < cnt; i++) begin
         repeat (BITCLK) @(negedge clk);
         got[i] = txd;
      end
   endtask

   task automatic wait_idle();
      int g;
      g = 0;
      while (tx_busy && g < 4000) begin
         @(negedge clk);
         g++;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [2:0] len, input logic [1:0] par, input logic two);
      cfg_len = len; cfg_par = par; cfg_two_stop = two;
   endtask

   task automatic loop_frame(input logic [8:0] d, input logic [2:0] len,
                             input logic [1:0] par, input logic two);
      logic [12:0] exp_f, got;
      int cnt, gap, v0, d0;
      exp_f = build_frame(d, len, par, two, 1'b0, 1'b0, 1'b0, cnt);
      use_loop = 1'b1;
      set_cfg(len, par, two);
      v0 = valid_cnt; d0 = done_cnt;
      @(negedge clk);
      tx_data = d; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      check(tx_busy === 1'b1, "R5 busy after start", 32'(tx_busy), 1);
      decode_tx(cnt, got, gap);
      check(got == exp_f, "R2 R3 R4 tx frame bits", 32'(got), 32'(exp_f));
      wait_idle();
      check(done_cnt == d0 + 1, "R5 one done pulse", 32'(done_cnt - d0), 1);
      check(valid_cnt == v0 + 1 && last_data == masked(d, len), "R7 loopback data",
            32'(last_data), 32'(masked(d, len)));
      check(!last_perr && !last_ferr, "R8 R9 clean frame flags",
            {30'd0, last_perr, last_ferr}, 0);
   endtask

   task automatic drive_rx(input logic [12:0] f, input int cnt);
      for (int i = 0; i < cnt; i++) begin
         bench_rxd = f[i];
         repeat (BITCLK) @(negedge clk);
      end
      bench_rxd = 1'b1;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic rx_case(input logic [8:0] d, input logic [2:0] len, input logic [1:0] par,
                          input logic two, input logic flip_p, input logic bad_s1,
                          input logic bad_s2, input logic exp_pe, input logic exp_fe,
                          input string tag);
      logic [12:0] f;
      int cnt, v0;
      use_loop = 1'b0;
      set_cfg(len, par, two);
      f = build_frame(d, len, par, two, flip_p, bad_s1, bad_s2, cnt);
      v0 = valid_cnt;
      drive_rx(f, cnt);
      repeat (BITCLK * 3) @(negedge clk);
      check(valid_cnt == v0 + 1, {tag, " valid count"}, 32'(valid_cnt - v0), 1);
      check(last_data == masked(d, len), {tag, " data"}, 32'(last_data), 32'(masked(d, len)));
      check(last_perr == exp_pe && last_ferr == exp_fe, {tag, " flags"},
            {30'd0, last_perr, last_ferr}, {30'd0, exp_pe, exp_fe});
   endtask

   initial begin : watchdog
      repeat (180000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [12:0] fa, fb, got;
      int ca, cb, gap, v0, d0;
      logic [8:0] held;
      void'($urandom(32'h5EED_0042));

      repeat (6) @(negedge clk);
      check(txd === 1'b1 && tx_busy === 1'b0 && tx_done === 1'b0, "R1 tx reset state",
            {29'd0, txd, tx_busy, tx_done}, 32'h4);
      check(rx_valid === 1'b0 && rx_data === 9'd0, "R1 rx reset data", 32'(rx_data), 0);
      check(rx_par_err === 1'b0 && rx_frm_err === 1'b0, "R1 rx reset flags",
            {30'd0, rx_par_err, rx_frm_err}, 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check(txd === 1'b1 && tx_busy === 1'b0, "R1 idle after release", 32'(txd), 1);

      // directed length corners, then random mixes (R2 R3 R4 R7)
      loop_frame(9'h1F5, 3'd0, 2'b01, 1'b0);
      loop_frame(9'h1A5, 3'd4, 2'b10, 1'b1);
      loop_frame(9'h155, 3'd7, 2'b11, 1'b0);
      for (int k = 0; k < 26; k++) begin
         loop_frame(9'($urandom), 3'($urandom), 2'($urandom), 1'($urandom));
      end

      // R8 bad parity bit, odd and even
      rx_case(9'h05A, 3'd2, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 odd parity error");
      rx_case(9'h133, 3'd4, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 even parity error");
      rx_case(9'h0C3, 3'd3, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 good parity");

      // R9 first stop low versus second stop low
      rx_case(9'h02D, 3'd1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 first stop low");
      rx_case(9'h0E1, 3'd3, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9 first of two low");
      rx_case(9'h096, 3'd3, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 second stop low");
      v0 = valid_cnt;
      repeat (BITCLK * 8) @(negedge clk);
      check(valid_cnt == v0, "R9 no extra frame after low second stop", 32'(valid_cnt - v0), 0);

      // R10 runt start pulse
      use_loop = 1'b0;
      set_cfg(3'd3, 2'b00, 1'b0);
      v0 = valid_cnt;
      bench_rxd = 1'b0;
      repeat (12) @(negedge clk);
      bench_rxd = 1'b1;
      repeat (BITCLK * 14) @(negedge clk);
      check(valid_cnt == v0, "R10 runt start ignored", 32'(valid_cnt - v0), 0);
      rx_case(9'h0B7, 3'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 frame after runt");

      // R7 hold
      held = rx_data;
      repeat (BITCLK * 6) @(negedge clk);
      check(rx_data == held, "R7 data held while idle", 32'(rx_data), 32'(held));

      // R5 start while busy ignored
      use_loop = 1'b1;
      set_cfg(3'd3, 2'b00, 1'b0);
      fa = build_frame(9'h0C9, 3'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, ca);
      d0 = done_cnt;
      @(negedge clk);
      tx_data = 9'h0C9; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      fork
         decode_tx(ca, got, gap);
         begin
            repeat (200) @(negedge clk);
            tx_data = 9'h036; tx_start = 1'b1;
            @(negedge clk);
            tx_start = 1'b0;
         end
      join
      check(got == fa, "R5 frame unchanged by busy start", 32'(got), 32'(fa));
      wait_idle();
      repeat (BITCLK * 4) @(negedge clk);
      check(done_cnt == d0 + 1 && !tx_busy && txd, "R5 busy start dropped",
            32'(done_cnt - d0), 1);

      // R6 back-to-back frames
      fa = build_frame(9'h0A1, 3'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, ca);
      fb = build_frame(9'h05E, 3'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, cb);
      d0 = done_cnt; v0 = valid_cnt;
      @(negedge clk);
      tx_data = 9'h0A1; tx_start = 1'b1;
      @(negedge clk);
      tx_data = 9'h05E;
      fork
         begin
            logic [12:0] ga, gb;
            int g1, g2;
            decode_tx(ca, ga, g1);
            decode_tx(cb, gb, g2);
            check(ga == fa, "R6 first frame", 32'(ga), 32'(fa));
            check(gb == fb, "R6 second frame", 32'(gb), 32'(fb));
            check(g2 <= BITCLK / 2 + 4, "R6 no idle gap", 32'(g2), BITCLK / 2);
         end
         begin
            int g;
            g = 0;
            while (!tx_done && g < 4000) begin
               @(negedge clk);
               g++;
            end
            tx_start = 1'b0;
         end
      join
      wait_idle();
      check(done_cnt == d0 + 2, "R6 two done pulses", 32'(done_cnt - d0), 2);
      check(valid_cnt == v0 + 2 && last_data == 9'h05E, "R6 second char received",
            32'(last_data), 32'h05E);

      // R11 config change during frame
      set_cfg(3'd3, 2'b00, 1'b0);
      fa = build_frame(9'h0A5, 3'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, ca);
      @(negedge clk);
      tx_data = 9'h0A5; tx_start = 1'b1;
      @(negedge clk);
      tx_start = 1'b0;
      fork
         decode_tx(ca, got, gap);
         begin
            repeat (150) @(negedge clk);
            set_cfg(3'd0, 2'b01, 1'b1);
         end
      join
      check(got == fa, "R11 frame keeps its settings", 32'(got), 32'(fa));
      wait_idle();
      check(last_data == 9'h0A5 && !last_perr && !last_ferr, "R11 receiver keeps settings",
            32'(last_data), 32'h0A5);
      loop_frame(9'h013, 3'd0, 2'b01, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule